// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reconfiguration

This block counts ticks from a separate slow oscillator. When the count reaches a period chosen by a 4-bit code, it raises an interrupt request, a system-reset request, or the interrupt first and the reset on the next expiry. The mode comes from two control bits: watchdog enable and interrupt enable. Software keeps the timer from expiring by pulsing a kick input, which clears the count. Software drives an 8-bit control/status register through a one-cycle write strobe and reads it back on a parallel read bus.

The enable bit and the period code are protected against stray writes. They change only inside a short window that is opened by a write with both the change-enable and enable bits set. An external watchdog-reset flag, held by the reset-cause logic, pins the enable bit on until that flag is cleared.

Top module: `wdog_guard`

## Requirements
- R1: After a synchronous reset the register reads 0x00, `irq_o` and `sys_rst_req_o` are low, and the enable bit (bit 3) takes the value of `wd_rst_flag_i`. The register layout is bit 7 interrupt flag, bit 6 interrupt enable, bit 5 period code bit 3, bit 4 change enable, bit 3 watchdog enable, bits 2..0 period code bits 2..0.
- R2: With a kick followed by continuous ticks, period code n (0 to 9) expires after 2^(BASE_LOG2+n) ticks, which is 2048·2^n by default. Codes 10 to 15 behave as code 9.
- R3: A write that falls outside an open window leaves the enable bit and the period code unchanged. The interrupt-flag and interrupt-enable bits of the same write still take effect.
- R4: A write with bits 4 and 3 both set opens a window. A write landing on any of the next four clock edges updates the enable bit and the period code. Bit 4 reads 1 while the window is open and clears itself when the window lapses; the guarded write also closes it.
- R5: With interrupt enable set and watchdog enable clear, an expiry sets the interrupt flag and `irq_o`, and no reset request is raised.
- R6: With watchdog enable set and interrupt enable clear, an expiry raises `sys_rst_req_o` for exactly one cycle and leaves the interrupt flag clear.
- R7: With both enables set, the first expiry sets the interrupt flag and clears interrupt enable without a reset request. The next expiry raises `sys_rst_req_o`.
- R8: The interrupt flag is cleared by a pulse on `irq_ack_i` or by writing 1 to bit 7.
- R9: While `wd_rst_flag_i` is high the enable bit reads 1, even after a guarded write of 0. Once the flag is low, a guarded write of 0 turns the enable bit off.
- R10: A kick clears the count. The count advances only on cycles with `tick_i` high.
- R11: If the period is shortened without a kick while the count already exceeds the new period, the timer expires on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_rst_flag_i | input | 1 | Watchdog-caused reset flag; forces the enable bit on |
| tick_i | input | 1 | One-cycle enable from the slow oscillator |
| kick_i | input | 1 | Clears the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request (interrupt flag) |
| irq_ack_i | input | 1 | Interrupt acknowledge; clears the flag |
| sys_rst_req_o | output | 1 | One-cycle system-reset request |

## Verification
The expiry distance is measured for all sixteen period codes in interrupt mode. This separates the correct power-of-two scaling from off-by-one counts and confirms that codes 10 to 15 saturate. Three tick patterns are also applied:
- Continuous ticks, with the same distance measured in reset-only mode and in combined mode, which separates the three mode responses.
- A held-low tick, which shows the count is gated.
- Periodic kicks, which keep the timer from expiring.

The guard is tried with writes landing on the fourth and on the fifth edge after an unlock, and with writes sent without any unlock. A period shortened mid-count shows whether the comparison is "at or beyond" rather than equality.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W  = 8;
  localparam int CODE_W = 4;
  localparam int B_IF   = 7;
  localparam int B_IE   = 6;
  localparam int B_P3   = 5;
  localparam int B_CE   = 4;
  localparam int B_EN   = 3;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_IRQ     = 2'd1,
    MODE_RST     = 2'd2,
    MODE_IRQ_RST = 2'd3
  } wd_mode_e;

  function automatic wd_mode_e mode_of(input logic en, input logic ie);
    return wd_mode_e'({en, ie});
  endfunction
endpackage

// File: rtl/wdog_unlock_win.sv
module wdog_unlock_win #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic consume,
  output logic open
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  logic [WIN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                   left_q <= '0;
    else if (arm)              left_q <= WIN_W'(WIN_CYC);
    else if (consume)          left_q <= '0;
    else if (left_q != '0)     left_q <= left_q - WIN_W'(1);
  end

  assign open = (left_q != '0);

  AST_WIN_ONLY_AFTER_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(open) |-> $past(arm));                                      // R4
  AST_WIN_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    (consume && !arm) |=> !open);                                     // R4
endmodule

// File: rtl/wdog_tick_cnt.sv
module wdog_tick_cnt
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int MAX_CODE  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              tick,
  input  logic              kick,
  input  logic [CODE_W-1:0] code,
  output logic              timeout
);
  localparam int CNT_W  = BASE_LOG2 + MAX_CODE + 1;
  localparam int N_CODE = 2 ** CODE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_tbl [N_CODE];
  logic [CNT_W-1:0] last_idx;

  for (genvar g = 0; g < N_CODE; g++) begin : g_dec
    localparam int EFF = (g > MAX_CODE) ? MAX_CODE : g;
    assign last_tbl[g] = (CNT_W'(1) << (BASE_LOG2 + EFF)) - CNT_W'(1);
  end

  assign last_idx = last_tbl[code];
  assign timeout  = active && tick && !kick && (cnt_q >= last_idx);

  always_ff @(posedge clk) begin
    if (rst || !active || kick) cnt_q <= '0;
    else if (tick)              cnt_q <= (cnt_q >= last_idx) ? '0 : cnt_q + CNT_W'(1);
  end

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt_q == '0));                                          // R10
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && !tick && !kick) |=> $stable(cnt_q));                   // R10
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int MAX_CODE  = 9,
  parameter int WIN_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wd_rst_flag_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o,
  input  logic             irq_ack_i,
  output logic             sys_rst_req_o
);
  logic              if_q, ie_q, en_q, rst_req_q;
  logic [CODE_W-1:0] per_q;
  logic              unlock_req, win_open, guarded_wr, tmo;
  wd_mode_e          mode;

  assign unlock_req = wr_en_i && wr_data_i[B_CE] && wr_data_i[B_EN];
  assign guarded_wr = wr_en_i && win_open;
  assign mode       = mode_of(en_q, ie_q);

  wdog_unlock_win #(.WIN_CYC(WIN_CYC)) u_win (
    .clk     (clk),
    .rst     (rst),
    .arm     (unlock_req),
    .consume (guarded_wr),
    .open    (win_open)
  );

  wdog_tick_cnt #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .active  (mode != MODE_OFF),
    .tick    (tick_i),
    .kick    (kick_i),
    .code    (per_q),
    .timeout (tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      if_q      <= 1'b0;
      ie_q      <= 1'b0;
      en_q      <= wd_rst_flag_i;
      per_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= tmo && (mode == MODE_RST);

      if (tmo && (mode == MODE_IRQ_RST)) ie_q <= 1'b0;
      else if (wr_en_i)                  ie_q <= wr_data_i[B_IE];

      if (tmo && ie_q)                                 if_q <= 1'b1;
      else if (irq_ack_i || (wr_en_i && wr_data_i[B_IF])) if_q <= 1'b0;

      en_q <= wd_rst_flag_i || (guarded_wr ? wr_data_i[B_EN] : en_q);
      if (guarded_wr) per_q <= {wr_data_i[B_P3], wr_data_i[2:0]};
    end
  end

  assign rd_data_o     = {if_q, ie_q, per_q[3], win_open, en_q, per_q[2:0]};
  assign irq_o         = if_q;
  assign sys_rst_req_o = rst_req_q;

  AST_EN_PINNED: assert property (@(posedge clk) disable iff (rst)
    wd_rst_flag_i |=> en_q);                                          // R9
  AST_PERIOD_GUARDED: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !win_open) |=> $stable(per_q));                       // R3
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req_o |=> !sys_rst_req_o);                                // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_i && !tmo) |=> !irq_o);                                  // R8
endmodule

// File: tb/wdog_guard_tb_top.sv
module wdog_guard_tb_top;
  localparam int BL = 4;

  logic       clk = 1'b0, rst = 1'b1, flag = 1'b0, tick = 1'b0, kick = 1'b0;
  logic       wr_en = 1'b0, ack = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic       irq, srq;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  wdog_guard #(.BASE_LOG2(BL)) dut_i (
    .clk(clk), .rst(rst), .wd_rst_flag_i(flag), .tick_i(tick), .kick_i(kick),
    .wr_en_i(wr_en), .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq),
    .irq_ack_i(ack), .sys_rst_req_o(srq)
  );

  // {period code, expected expiry distance in ticks} for BASE_LOG2 = 4
  localparam logic [19:0] VEC [0:15] = '{
    {4'd0, 16'd16},   {4'd1, 16'd32},   {4'd2, 16'd64},   {4'd3, 16'd128},
    {4'd4, 16'd256},  {4'd5, 16'd512},  {4'd6, 16'd1024}, {4'd7, 16'd2048},
    {4'd8, 16'd4096}, {4'd9, 16'd8192}, {4'd10, 16'd8192}, {4'd11, 16'd8192},
    {4'd12, 16'd8192}, {4'd13, 16'd8192}, {4'd14, 16'd8192}, {4'd15, 16'd8192}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wd = d; step(); wr_en = 1'b0;
  endtask

  task automatic pulse_kick;
    kick = 1'b1; step(); kick = 1'b0;
  endtask

  task automatic do_reset;
    rst = 1'b1; step(2); rst = 1'b0;
  endtask

  task automatic wait_ev(input bit use_irq, input int lim, output int k);
    k = 0;
    while (((use_irq ? irq : srq) == 1'b0) && k < lim) begin
      step(); k++;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int  k;
    bit  seen;
    step(2);
    do_reset();
    // R1 reset state
    chk("R1 rd", rd, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 srq", srq, 0);

    // R3 guarded bits ignored without unlock, IE still written
    wr(8'h0D); chk("R3 en/period ignored", rd, 8'h00);
    wr(8'h40); chk("R3 ie accepted", rd, 8'h40);
    wr(8'h00);

    // R2 / R5 period decode walk in interrupt mode
    tick = 1'b1;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] c;
      c = VEC[i][19:16];
      wr(8'hC0);
      wr(8'h58);
      wr({2'b01, c[3], 2'b00, c[2:0]});
      wr(8'hC0);
      pulse_kick();
      wait_ev(1'b1, 20000, k);
      chk($sformatf("R2 code %0d distance", c), k, VEC[i][15:0]);
      chk("R5 no reset in irq mode", srq, 0);
    end

    // R4 window boundaries
    tick = 1'b0;
    do_reset();
    wr(8'h18); chk("R4 ce set by unlock", rd, 8'h10);
    step(3);
    wr(8'h0A); chk("R4 write on 4th edge accepted", rd, 8'h0A);
    wr(8'h18); step(4);
    chk("R4 ce self-clears", rd, 8'h0A);
    wr(8'h02); chk("R4 write on 5th edge ignored", rd, 8'h0A);

    // R6 reset-only mode
    do_reset();
    wr(8'h18); wr(8'h08);
    tick = 1'b1;
    pulse_kick();
    wait_ev(1'b0, 1000, k);
    chk("R6 reset distance", k, 16);
    chk("R6 no irq", irq, 0);
    step();
    chk("R6 one-cycle pulse", srq, 0);

    // R10 kicks and tick gating
    seen = 1'b0;
    pulse_kick();
    for (int j = 0; j < 6; j++) begin
      for (int m = 0; m < 10; m++) begin step(); if (srq) seen = 1'b1; end
      pulse_kick();
    end
    chk("R10 kicks prevent reset", seen, 0);
    tick = 1'b0;
    pulse_kick();
    for (int m = 0; m < 100; m++) begin step(); if (srq) seen = 1'b1; end
    chk("R10 no tick no expiry", seen, 0);
    tick = 1'b1;
    wait_ev(1'b0, 1000, k);
    chk("R10 count held at zero", k, 16);

    // R7 combined mode
    do_reset();
    wr(8'h40); wr(8'h58); wr(8'h48);
    pulse_kick();
    wait_ev(1'b1, 1000, k);
    chk("R7 first expiry distance", k, 16);
    chk("R7 no reset on first", srq, 0);
    chk("R7 ie cleared", rd[6], 0);
    wait_ev(1'b0, 1000, k);
    chk("R7 reset on second", k, 16);

    // R8 flag clearing
    ack = 1'b1; step(); ack = 1'b0;
    chk("R8 ack clears", irq, 0);
    wr(8'h40); pulse_kick();
    wait_ev(1'b1, 1000, k);
    chk("R8 flag set again", irq, 1);
    wr(8'hC0);
    chk("R8 write-one clears", irq, 0);

    // R9 enable pinned by reset flag
    tick = 1'b0;
    flag = 1'b1;
    do_reset();
    chk("R1 en follows flag", rd, 8'h08);
    wr(8'h18); wr(8'h00);
    chk("R9 en stays on", rd[3], 1);
    flag = 1'b0; step();
    wr(8'h18); wr(8'h00);
    chk("R9 en off after flag clear", rd, 8'h00);

    // R11 shorter period without kick
    do_reset();
    tick = 1'b1;
    wr(8'h40); wr(8'h58); wr(8'h42);
    pulse_kick();
    step(40);
    wr(8'h58); wr(8'h40);
    chk("R11 not yet", irq, 0);
    step();
    chk("R11 immediate expiry", irq, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule